// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Edge Interrupts

This block drives and samples sixteen general-purpose pins behind a small register bus. Software programs, pin by pin, the value to drive, whether the pin is driven at all, which edge (rising or falling) of an incoming signal is of interest, and whether that pin may raise an interrupt. Every external input goes through a two-flop synchronizer. The synchronized value is compared with its value on the previous cycle to find edges.

A qualifying edge latches a bit in a sticky status register. One level interrupt line stays high while any status bit is set. Software acknowledges events by writing ones to the status register. A separate pin-enable mask gates the value that software reads back from the input register. Read data appears one clock after the read strobe. Writes land on the next clock edge.

Top module: `gpio16_ctrl`

## Requirements
- R1: After reset the sampled inputs and the status register are 0, and the drive value, direction, edge select, interrupt mask and pin-enable mask are all 0xFFFF. The read data port is 0 and irq is 0.
- R2: Registers sit at byte offsets 0x00 input (read-only), 0x04 drive value, 0x08 direction, 0x0C edge select, 0x10 interrupt mask, 0x14 status and 0x18 pin-enable mask. A write with bus_we takes effect at the next clock edge. bus_rdata shows the addressed register one clock after bus_re is sampled, and otherwise holds its last value.
- R3: pin_oe bit i is 1 exactly when direction bit i is 0. A direction bit of 1 means the pin is an input. pin_out carries the drive-value register.
- R4: Edge-select bit i = 1 selects a rising edge of synchronized input i. Edge-select bit i = 0 selects a falling edge. An edge of the other polarity sets nothing.
- R5: A selected edge sets status bit i only when direction bit i is 1 and interrupt mask bit i is 0.
- R6: irq is a register output and equals the OR of all status bits in every cycle.
- R7: Writing the status offset clears each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R8: When a new edge for bit i and a clear of bit i happen in the same cycle, status bit i ends up 1.
- R9: Reading offset 0x00 returns the synchronized inputs ANDed with the pin-enable mask. A pin change is visible at the synchronizer output two clock edges after it is applied.
- R10: Writes to offset 0x00 or to any unmapped offset change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid one clock after bus_re |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Per-pin drive values |
| pin_oe | output | 16 | Per-pin output enables |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The hardest case to reach is a fresh edge on a pin landing in the same clock edge as a software clear of that same status bit. The bench first sets the bit with one rising edge, then drops the pin. It then raises the pin again and places the status write exactly two falling clock edges later, which is the cycle the synchronizer delivers the edge. It also reaches edges of the unselected polarity, and edges on output-direction and masked pins. After each of these it reads the status register back, so that a missing change can be told apart from a wrong one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned GPIO_AW = 8;
  localparam logic [GPIO_AW-1:0] OFS_DIN   = 8'h00;
  localparam logic [GPIO_AW-1:0] OFS_DOUT  = 8'h04;
  localparam logic [GPIO_AW-1:0] OFS_DIR   = 8'h08;
  localparam logic [GPIO_AW-1:0] OFS_EDGE  = 8'h0C;
  localparam logic [GPIO_AW-1:0] OFS_MASK  = 8'h10;
  localparam logic [GPIO_AW-1:0] OFS_STAT  = 8'h14;
  localparam logic [GPIO_AW-1:0] OFS_PINEN = 8'h18;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] din_sync,
  output logic [W-1:0] din_prev
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign din_sync = sync_q;
  assign din_prev = prev_q;

  // A pin change reaches the synchronized output two edges later  // R9
  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q == $past(meta_q)) else $error("sync latency");  // R9
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = GPIO_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_re,
  input  logic [W-1:0]  din_sync,
  input  logic [W-1:0]  status,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  dout,
  output logic [W-1:0]  dir,
  output logic [W-1:0]  edge_sel,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  clr
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] dout_q, dir_q, edge_q, mask_q, pinen_q, rdata_q;
  logic [W-1:0] dout_d, dir_d, edge_d, mask_d, pinen_d, rdata_d;
  logic [W-1:0] rd_mux;
  logic         wr_dout, wr_dir, wr_edge, wr_mask, wr_pinen, wr_stat;
  logic         rd_mapped;

  // write decode
  always_comb begin
    wr_dout  = bus_we && (bus_addr == OFS_DOUT);
    wr_dir   = bus_we && (bus_addr == OFS_DIR);
    wr_edge  = bus_we && (bus_addr == OFS_EDGE);
    wr_mask  = bus_we && (bus_addr == OFS_MASK);
    wr_pinen = bus_we && (bus_addr == OFS_PINEN);
    wr_stat  = bus_we && (bus_addr == OFS_STAT);
  end

  // next state with explicit enables
  always_comb begin
    dout_d  = wr_dout  ? bus_wdata : dout_q;
    dir_d   = wr_dir   ? bus_wdata : dir_q;
    edge_d  = wr_edge  ? bus_wdata : edge_q;
    mask_d  = wr_mask  ? bus_wdata : mask_q;
    pinen_d = wr_pinen ? bus_wdata : pinen_q;
    clr     = wr_stat  ? bus_wdata : '0;
  end

  // read mux
  always_comb begin
    rd_mapped = 1'b1;
    unique case (bus_addr)
      OFS_DIN:   rd_mux = din_sync & pinen_q;
      OFS_DOUT:  rd_mux = dout_q;
      OFS_DIR:   rd_mux = dir_q;
      OFS_EDGE:  rd_mux = edge_q;
      OFS_MASK:  rd_mux = mask_q;
      OFS_STAT:  rd_mux = status;
      OFS_PINEN: rd_mux = pinen_q;
      default: begin
        rd_mux    = '0;
        rd_mapped = 1'b0;
      end
    endcase
    rdata_d = bus_re ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= ONES;
      dir_q   <= ONES;
      edge_q  <= ONES;
      mask_q  <= ONES;
      pinen_q <= ONES;
      rdata_q <= '0;
    end else begin
      dout_q  <= dout_d;
      dir_q   <= dir_d;
      edge_q  <= edge_d;
      mask_q  <= mask_d;
      pinen_q <= pinen_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign dout      = dout_q;
  assign dir       = dir_q;
  assign edge_sel  = edge_q;
  assign mask      = mask_q;

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_addr == OFS_DIR) |-> dir_q == $past(bus_wdata)) else $error("dir write");  // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_re) |-> $stable(bus_rdata)) else $error("rdata hold");  // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re && !rd_mapped) |-> bus_rdata == '0) else $error("unmapped read");  // R10
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> ($stable(dout_q) && $stable(mask_q) && $stable(pinen_q))) else $error("stray write");  // R10
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_sync,
  input  logic [W-1:0] din_prev,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] rise, fall, hit;
  logic [W-1:0] status_q, status_d;
  logic         irq_q, irq_d;

  always_comb begin
    rise     = din_sync & ~din_prev;
    fall     = ~din_sync & din_prev;
    hit      = ((rise & edge_sel) | (fall & ~edge_sel)) & dir & ~mask;
    status_d = (status_q & ~clr) | hit;
    irq_d    = |status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

  AST_SET_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) & ~$past(dir & ~mask)) == '0) else $error("unqualified set");  // R5
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (status_q != '0)) else $error("irq mismatch");  // R6
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & $past(clr) & ~$past(hit)) == '0) else $error("clear failed");  // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (~status_q & $past(hit)) == '0) else $error("set lost");  // R8
endmodule

// File: rtl/gpio16_ctrl.sv
module gpio16_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = GPIO_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_re,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  logic         rst_sync_n;
  logic [W-1:0] din_sync, din_prev;
  logic [W-1:0] dout, dir, edge_sel, mask, clr, status;

  gpio_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gpio_in_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_in(pin_in),
    .din_sync(din_sync), .din_prev(din_prev)
  );

  gpio_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .din_sync(din_sync), .status(status), .bus_rdata(bus_rdata),
    .dout(dout), .dir(dir), .edge_sel(edge_sel), .mask(mask), .clr(clr)
  );

  gpio_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n),
    .din_sync(din_sync), .din_prev(din_prev), .dir(dir), .mask(mask),
    .edge_sel(edge_sel), .clr(clr), .status(status), .irq(irq)
  );

  assign pin_out = dout;
  assign pin_oe  = ~dir;

  AST_OE_AFTER_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_we && bus_addr == OFS_DIR) |-> pin_oe == ~$past(bus_wdata)) else $error("oe");  // R3
endmodule

// File: tb/sim_gpio16_ctrl.sv
module sim_gpio16_ctrl;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic        bus_re;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq;

  int n_chk;
  int n_fail;
  int cycles;

  gpio16_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // {offset, write data, expected read}
  localparam logic [39:0] VEC [9] = '{
    {8'h04, 16'hA5C3, 16'hA5C3},
    {8'h08, 16'h0F0F, 16'h0F0F},
    {8'h0C, 16'h00FF, 16'h00FF},
    {8'h10, 16'h1234, 16'h1234},
    {8'h18, 16'hFF00, 16'hFF00},
    {8'h14, 16'hFFFF, 16'h0000},
    {8'h00, 16'hBEEF, 16'h0000},
    {8'h1C, 16'h5555, 16'h0000},
    {8'h02, 16'h1111, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin_in = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  logic [15:0] r;

  initial begin
    n_chk = 0; n_fail = 0; cycles = 0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0; pin_in = '0;
    do_reset();

    // R1 reset state
    chk("R1 rdata", bus_rdata, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    chk("R1 pin_oe", pin_oe, 16'h0000);
    chk("R1 pin_out", pin_out, 16'hFFFF);
    rd(8'h08, r); chk("R1 dir", r, 16'hFFFF);
    rd(8'h0C, r); chk("R1 edge", r, 16'hFFFF);
    rd(8'h10, r); chk("R1 mask", r, 16'hFFFF);
    rd(8'h14, r); chk("R1 status", r, 16'h0000);
    rd(8'h18, r); chk("R1 pinen", r, 16'hFFFF);
    rd(8'h00, r); chk("R1 input", r, 16'h0000);

    // R2 / R10 vector walk
    foreach (VEC[i]) begin
      wr(VEC[i][39:32], VEC[i][31:16]);
      rd(VEC[i][39:32], r);
      chk("R2 R10 vector", r, VEC[i][15:0]);
    end
    // R2 hold without strobe
    wait_cyc(2);
    chk("R2 hold", bus_rdata, 16'h0000);
    rd(8'h04, r); chk("R10 dout untouched", r, 16'hA5C3);

    do_reset();
    // R3 direction
    wr(8'h08, 16'h00FF);
    wr(8'h04, 16'h3C00);
    chk("R3 pin_oe", pin_oe, 16'hFF00);
    chk("R3 pin_out", pin_out, 16'h3C00);
    wr(8'h10, 16'h0080);
    wr(8'h0C, 16'h000F);

    // R4 rising on pin0
    @(negedge clk); pin_in = 16'h0001; wait_cyc(3);
    rd(8'h14, r); chk("R4 rise", r, 16'h0001);
    chk("R6 irq high", {15'd0, irq}, 16'h0001);
    // R4 rise on falling-select pin4 ignored, then fall counts
    @(negedge clk); pin_in = 16'h0011; wait_cyc(3);
    rd(8'h14, r); chk("R4 wrong polarity", r, 16'h0001);
    @(negedge clk); pin_in = 16'h0001; wait_cyc(3);
    rd(8'h14, r); chk("R4 fall", r, 16'h0011);
    // R5 output pin8 and masked pin7
    @(negedge clk); pin_in = 16'h0181; wait_cyc(3);
    @(negedge clk); pin_in = 16'h0001; wait_cyc(3);
    rd(8'h14, r); chk("R5 output/masked ignored", r, 16'h0011);

    // R7 write-one-to-clear
    wr(8'h14, 16'h0001);
    rd(8'h14, r); chk("R7 partial clear", r, 16'h0010);
    chk("R6 irq still high", {15'd0, irq}, 16'h0001);
    wr(8'h14, 16'h0010);
    chk("R6 irq low", {15'd0, irq}, 16'h0000);
    rd(8'h14, r); chk("R7 all clear", r, 16'h0000);

    // R8 set wins over clear
    @(negedge clk); pin_in = 16'h0000; wait_cyc(3);
    @(negedge clk); pin_in = 16'h0001; wait_cyc(3);
    rd(8'h14, r); chk("R8 preset", r, 16'h0001);
    @(negedge clk); pin_in = 16'h0000; wait_cyc(3);
    @(negedge clk); pin_in = 16'h0001;
    @(negedge clk);
    wr(8'h14, 16'h0001);
    rd(8'h14, r); chk("R8 set wins", r, 16'h0001);
    wr(8'h14, 16'h0001);
    rd(8'h14, r); chk("R8 later clear", r, 16'h0000);

    // R9 input read gated by pin-enable
    @(negedge clk); pin_in = 16'h00F0; wait_cyc(3);
    rd(8'h00, r); chk("R9 input", r, 16'h00F0);
    wr(8'h18, 16'h00A0);
    rd(8'h00, r); chk("R9 gated", r, 16'h00A0);
    @(negedge clk); pin_in = 16'h0000;
    rd(8'h00, r); chk("R9 one edge not yet", r, 16'h00A0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule